// File: doc/BRIEF.md
# Progressive RGB to Interlaced 4:2:2 Byte-Stream Formatter

This block sits between a progressive 24-bit RGB pixel source and a digital TV encoder. Each pixel is converted to YCbCr with fixed-point studio-range coefficients. Chroma is halved horizontally by averaging each pair of neighbouring pixels. The result is serialised as one byte per cycle in the order Cb, Y, Cr, Y. The block also builds the full line and field timing around the picture: an end-of-active-video code, horizontal blanking, a start-of-active-video code, then the active samples. Each timing code is four bytes long and ends in a protected flag byte.

For interlacing, the source delivers one complete progressive frame for every output field. In the first field the block keeps the 1st, 3rd, 5th... source lines and drops the rest. In the second field it keeps the 2nd, 4th... lines. A mode pin selects 525-line or 625-line field geometry. The line and pixel counts are parameters and default to small values. A `field_o` pin tracks which field is being sent.

Both streams use valid/ready. A pixel transfers on a clock edge where `pix_valid_i` and `pix_ready_o` are both high. `pix_ready_o` does not depend on `pix_valid_i`. An output byte transfers when `byte_valid_o` and `byte_ready_i` are both high. While `byte_valid_o` is high and the byte is not taken, the byte stays unchanged. The output only stalls (`byte_valid_o` low) at the first byte of an active sample group whose pixel pair has not yet arrived. Back-pressure on the output stalls the timing counters and, through the pair buffer, the pixel input.

Top module: `tv656_formatter`

## Requirements
- R1: An output byte offered with `byte_valid_o` high stays valid and unchanged until `byte_ready_i` takes it. A pixel is consumed only on a clock edge where `pix_valid_i` and `pix_ready_o` are both high.
- R2: Every line has the following parts, in order:
  - 4 code bytes FF 00 00 XY marking end of active video,
  - HB blanking bytes,
  - 4 code bytes FF 00 00 XY marking start of active video,
  - 2·W sample bytes.
  HB must be a multiple of 4, and W must be even.
- R3: The XY byte, from bit 7 down to bit 0, is 1, F, V, H, V^H, F^H, F^V, F^V^H.
  - H is 1 in the end code and 0 in the start code.
  - V is 1 on vertical-blanking lines.
  - F is 0 in the first field and 1 in the second.
- R4: Blanking bytes alternate 0x80, 0x10, starting with 0x80. This applies both after the end code and in the sample region of vertical-blanking lines.
- R5: Luma is Y = ((66R+129G+25B+128)>>8)+16, clamped to 16..235. Both luma bytes of a group come from their own pixel, in arrival order.
- R6: Chroma is computed per pixel and then averaged over the pair:
  - Cb = ((−38R−74G+112B+128)>>8)+128 and Cr = ((112R−94G−18B+128)>>8)+128, each clamped to 16..240;
  - the group carries (Cb0+Cb1+1)>>1 and (Cr0+Cr1+1)>>1;
  - the byte order in a group is Cb, Y0, Cr, Y1.
- R7: The field geometry is VBL blanking lines followed by ACT active lines. The 525 set is used when `mode_625_i` is 0 and the 625 set when it is 1. The mode is sampled only while reset is asserted; changes after reset have no effect.
- R8: Each field consumes 2·ACT source lines of W pixels. The first field sends source lines 0, 2, 4...; the second field sends 1, 3, 5.... Dropped lines are accepted and discarded.
- R9: `field_o` is low for the first field and high for the second. It changes only on the clock edge that moves the output to the first end-code byte of the next field.
- R10: After reset, the block offers the FF byte of line 0 of the first field, `field_o` is 0 and `pix_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/byte clock |
| rst_n | input | 1 | Active-low reset; mode is captured while low |
| mode_625_i | input | 1 | 0: 525-line geometry, 1: 625-line geometry |
| pix_valid_i | input | 1 | Pixel offered |
| pix_ready_o | output | 1 | Pixel can be taken |
| pix_rgb_i | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| byte_valid_o | output | 1 | Output byte offered |
| byte_ready_i | input | 1 | Sink takes the byte |
| byte_o | output | 8 | Output byte |
| field_o | output | 1 | 0 in first field, 1 in second |

## Verification
Timing bytes and blanking bytes are decoded from counters and are due in the same cycle the counter reaches them. A sample group's Cb byte is due on the cycle after the second pixel of the pair is accepted, provided the counter is at the group start. The Y0, Cr and Y1 bytes follow one per accepted byte. `field_o` flips on the edge that enters the first end code of the next field, so it is compared together with each byte. The bench drives inputs on the falling edge and compares each byte on the falling edge where both valid and ready are high, in queue order, so that random gaps on either side only shift when a byte is due, never its value.

// File: rtl/tv656_pkg.sv
package tv656_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] cb;
    logic [7:0] cr;
  } ycc_t;

  // Saturate a signed intermediate into [lo, hi].
  function automatic logic [7:0] sat8(input logic signed [17:0] v,
                                      input logic [7:0] lo,
                                      input logic [7:0] hi);
    logic signed [17:0] slo, shi;
    slo = $signed({10'd0, lo});
    shi = $signed({10'd0, hi});
    if (v < slo)      return lo;
    else if (v > shi) return hi;
    else              return v[7:0];
  endfunction

  // Protected flag byte of a timing code.
  function automatic logic [7:0] flag_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/tv656_csc.sv
module tv656_csc
  import tv656_pkg::*;
(
  input  rgb_t pix_i,
  output ycc_t ycc_o
);
  logic signed [17:0] r, g, b;
  logic signed [17:0] ys, cbs, crs;

  always_comb begin
    r   = {10'd0, pix_i.r};
    g   = {10'd0, pix_i.g};
    b   = {10'd0, pix_i.b};
    ys  = ((18'sd66 * r + 18'sd129 * g + 18'sd25 * b + 18'sd128) >>> 8) + 18'sd16;
    cbs = ((18'sd112 * b - 18'sd38 * r - 18'sd74 * g + 18'sd128) >>> 8) + 18'sd128;
    crs = ((18'sd112 * r - 18'sd94 * g - 18'sd18 * b + 18'sd128) >>> 8) + 18'sd128;
    ycc_o.y  = sat8(ys,  8'd16, 8'd235);
    ycc_o.cb = sat8(cbs, 8'd16, 8'd240);
    ycc_o.cr = sat8(crs, 8'd16, 8'd240);
  end
endmodule

// File: rtl/tv656_intake.sv
module tv656_intake
  import tv656_pkg::*;
#(
  parameter int W        = 8,
  parameter int ACT_525  = 3,
  parameter int ACT_625  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  input  rgb_t in_pix_i,
  input  logic take_i,
  output logic full_o,
  output rgb_t p0_o,
  output rgb_t p1_o
);
  localparam int SRC_MAX = 2 * ((ACT_525 > ACT_625) ? ACT_525 : ACT_625);
  localparam int PW      = (W > 1) ? $clog2(W) : 1;
  localparam int SW      = $clog2(SRC_MAX + 1);

  logic [PW-1:0] px;
  logic [SW-1:0] sl;
  logic          fld, half, full;
  rgb_t          p0, p1;
  logic [SW-1:0] last_sl;
  logic          keep, acc;

  always_comb begin
    last_sl    = mode_i ? SW'(2 * ACT_625 - 1) : SW'(2 * ACT_525 - 1);
    keep       = (sl[0] == fld);
    in_ready_o = keep ? !full : 1'b1;
    acc        = in_valid_i && in_ready_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px   <= '0;
      sl   <= '0;
      fld  <= 1'b0;
      half <= 1'b0;
      full <= 1'b0;
      p0   <= '0;
      p1   <= '0;
    end else begin
      if (take_i) full <= 1'b0;
      if (acc) begin
        if (keep) begin
          if (!half) begin
            p0   <= in_pix_i;
            half <= 1'b1;
          end else begin
            p1   <= in_pix_i;
            half <= 1'b0;
            full <= 1'b1;
          end
        end
        if (px == PW'(W - 1)) begin
          px <= '0;
          if (sl == last_sl) begin
            sl  <= '0;
            fld <= ~fld;
          end else begin
            sl <= sl + 1'b1;
          end
        end else begin
          px <= px + 1'b1;
        end
      end
    end
  end

  assign full_o = full;
  assign p0_o   = p0;
  assign p1_o   = p1;
endmodule

// File: rtl/tv656_timing.sv
module tv656_timing #(
  parameter int W       = 8,
  parameter int HB      = 8,
  parameter int VBL_525 = 2,
  parameter int ACT_525 = 3,
  parameter int VBL_625 = 3,
  parameter int ACT_625 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_i,
  input  logic       step_i,
  output logic       eav_o,
  output logic       sav_o,
  output logic       hbl_o,
  output logic       act_o,
  output logic       vbl_o,
  output logic [1:0] phase_o,
  output logic       odd_o,
  output logic       fld_o
);
  localparam int LB   = 8 + HB + 2 * W;
  localparam int BW   = $clog2(LB);
  localparam int L525 = VBL_525 + ACT_525;
  localparam int L625 = VBL_625 + ACT_625;
  localparam int LMAX = (L525 > L625) ? L525 : L625;
  localparam int LNW  = $clog2(LMAX + 1);

  logic [BW-1:0]  bc;
  logic [LNW-1:0] ln;
  logic           fld;
  int             vb_n, ln_n;

  always_comb begin
    vb_n = mode_i ? VBL_625 : VBL_525;
    ln_n = mode_i ? L625 : L525;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc  <= '0;
      ln  <= '0;
      fld <= 1'b0;
    end else if (step_i) begin
      if (int'(bc) == LB - 1) begin
        bc <= '0;
        if (int'(ln) == ln_n - 1) begin
          ln  <= '0;
          fld <= ~fld;
        end else begin
          ln <= ln + 1'b1;
        end
      end else begin
        bc <= bc + 1'b1;
      end
    end
  end

  always_comb begin
    eav_o   = int'(bc) < 4;
    hbl_o   = int'(bc) >= 4 && int'(bc) < 4 + HB;
    sav_o   = int'(bc) >= 4 + HB && int'(bc) < 8 + HB;
    act_o   = int'(bc) >= 8 + HB;
    vbl_o   = int'(ln) < vb_n;
    phase_o = bc[1:0];
    odd_o   = bc[0];
    fld_o   = fld;
  end
endmodule

// File: rtl/tv656_formatter.sv
module tv656_formatter
  import tv656_pkg::*;
#(
  parameter int W       = 8,
  parameter int HB      = 8,
  parameter int VBL_525 = 2,
  parameter int ACT_525 = 3,
  parameter int VBL_625 = 3,
  parameter int ACT_625 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_625_i,
  input  logic        pix_valid_i,
  output logic        pix_ready_o,
  input  logic [23:0] pix_rgb_i,
  output logic        byte_valid_o,
  input  logic        byte_ready_i,
  output logic [7:0]  byte_o,
  output logic        field_o
);
  logic mode_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_625_i;
  end

  logic       t_eav, t_sav, t_hbl, t_act, t_vbl, t_odd, t_fld;
  logic [1:0] phase;
  logic       step, take, pair_full, active_video;
  rgb_t       pair [2];
  ycc_t       cv   [2];

  tv656_intake #(.W(W), .ACT_525(ACT_525), .ACT_625(ACT_625)) u_intake (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q),
    .in_valid_i(pix_valid_i), .in_ready_o(pix_ready_o), .in_pix_i(rgb_t'(pix_rgb_i)),
    .take_i(take), .full_o(pair_full), .p0_o(pair[0]), .p1_o(pair[1])
  );

  tv656_timing #(.W(W), .HB(HB), .VBL_525(VBL_525), .ACT_525(ACT_525),
                 .VBL_625(VBL_625), .ACT_625(ACT_625)) u_timing (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .step_i(step),
    .eav_o(t_eav), .sav_o(t_sav), .hbl_o(t_hbl), .act_o(t_act), .vbl_o(t_vbl),
    .phase_o(phase), .odd_o(t_odd), .fld_o(t_fld)
  );

  for (genvar i = 0; i < 2; i++) begin : g_lane
    tv656_csc u_csc (.pix_i(pair[i]), .ycc_o(cv[i]));
  end

  logic [8:0] cb_sum, cr_sum;
  logic [7:0] cb_avg, cr_avg;
  logic [7:0] h_y0, h_cr, h_y1;

  always_comb begin
    cb_sum       = {1'b0, cv[0].cb} + {1'b0, cv[1].cb} + 9'd1;
    cr_sum       = {1'b0, cv[0].cr} + {1'b0, cv[1].cr} + 9'd1;
    cb_avg       = cb_sum[8:1];
    cr_avg       = cr_sum[8:1];
    active_video = t_act && !t_vbl;
    byte_valid_o = !(active_video && phase == 2'd0 && !pair_full);
    step         = byte_valid_o && byte_ready_i;
    take         = step && active_video && phase == 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_y0 <= 8'h10;
      h_cr <= 8'h80;
      h_y1 <= 8'h10;
    end else if (take) begin
      h_y0 <= cv[0].y;
      h_cr <= cr_avg;
      h_y1 <= cv[1].y;
    end
  end

  always_comb begin
    if (t_eav || t_sav) begin
      case (phase)
        2'd0:    byte_o = 8'hFF;
        2'd3:    byte_o = flag_byte(t_fld, t_vbl, t_eav);
        default: byte_o = 8'h00;
      endcase
    end else if (t_hbl || !active_video) begin
      byte_o = t_odd ? 8'h10 : 8'h80;
    end else begin
      case (phase)
        2'd0:    byte_o = cb_avg;
        2'd1:    byte_o = h_y0;
        2'd2:    byte_o = h_cr;
        default: byte_o = h_y1;
      endcase
    end
  end

  assign field_o = t_fld;
endmodule

// File: rtl/tv656_chk.sv
module tv656_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_d,
  input logic       field,
  input logic       mode_q,
  input logic       act_video
);
  // R1
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_d));

  // R5
  sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && act_video |-> byte_d >= 8'd16 && byte_d <= 8'd240);

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  // R9
  field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && field != $past(field) |-> byte_valid && byte_d == 8'hFF);

  // R9
  field_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && byte_ready) |=> $stable(field));
endmodule

bind tv656_formatter tv656_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid_o), .byte_ready(byte_ready_i),
  .byte_d(byte_o), .field(field_o), .mode_q(mode_q), .act_video(active_video)
);

// File: tb/tv656_formatter_tb.sv
`timescale 1ns/1ps
module tv656_formatter_tb_top;
  localparam int W = 8, HB = 8;
  localparam int VB525 = 2, AC525 = 3, VB625 = 3, AC625 = 4;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic pix_valid = 1'b0, pix_ready, byte_valid, byte_ready = 1'b0, field;
  logic [23:0] pix = '0;
  logic [7:0]  bo;

  always #2.5 clk = ~clk;

  tv656_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .mode_625_i(mode),
    .pix_valid_i(pix_valid), .pix_ready_o(pix_ready), .pix_rgb_i(pix),
    .byte_valid_o(byte_valid), .byte_ready_i(byte_ready), .byte_o(bo), .field_o(field)
  );

  typedef struct { logic [7:0] b; logic f; string tag; } exp_t;
  exp_t q[$];
  int runs = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [23:0] pat(input int g, input int s, input int x);
    logic [31:0] h;
    if (s == 0 && x < 4) begin
      case (x)
        0: return 24'hFFFFFF;
        1: return 24'h000000;
        2: return 24'h0000FF;
        default: return 24'hFF0000;
      endcase
    end
    h = (g * 32'h9E3779B1) ^ (s * 32'h85EBCA6B) ^ (x * 32'hC2B2AE35);
    h = h ^ (h >> 13);
    return h[23:0];
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // R5 / R6 reference conversion
  function automatic void conv(input logic [23:0] p, output int y, output int cb, output int cr);
    int r, g, b;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    y  = clampi(((66*r + 129*g + 25*b + 128) >>> 8) + 16, 16, 235);
    cb = clampi(((-38*r - 74*g + 112*b + 128) >>> 8) + 128, 16, 240);
    cr = clampi(((112*r - 94*g - 18*b + 128) >>> 8) + 128, 16, 240);
  endfunction

  task automatic push(input int b, input logic f, input string tag);
    exp_t e;
    e.b = 8'(b); e.f = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic code4(input logic f, input logic v, input logic h);
    push(8'hFF, f, "R2"); push(8'h00, f, "R2"); push(8'h00, f, "R2");
    push({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h}, f, "R3");
  endtask

  task automatic build(input logic m, input int nf, input int g0);
    int vb, ac;
    vb = m ? VB625 : VB525;
    ac = m ? AC625 : AC525;
    for (int fi = 0; fi < nf; fi++) begin
      logic fb;
      fb = 1'(fi % 2);
      for (int l = 0; l < vb + ac; l++) begin
        logic v;
        v = (l < vb);
        code4(fb, v, 1'b1);
        for (int k = 0; k < HB; k++) push(k % 2 ? 8'h10 : 8'h80, fb, "R4");
        code4(fb, v, 1'b0);
        if (v) begin
          for (int k = 0; k < 2 * W; k++) push(k % 2 ? 8'h10 : 8'h80, fb, "R4");
        end else begin
          // R8: first field keeps even source index, second field odd
          int s;
          s = 2 * (l - vb) + int'(fb);
          for (int x = 0; x < W; x += 2) begin
            int y0, b0, r0, y1, b1, r1;
            conv(pat(g0 + fi, s, x), y0, b0, r0);
            conv(pat(g0 + fi, s, x + 1), y1, b1, r1);
            push((b0 + b1 + 1) >> 1, fb, "R6,R8");
            push(y0, fb, "R5,R8");
            push((r0 + r1 + 1) >> 1, fb, "R6,R8");
            push(y1, fb, "R5,R8");
          end
        end
      end
    end
  endtask

  task automatic send(input logic [23:0] p);
    @(negedge clk);
    pix_valid = 1'b1;
    pix = p;
    while (!pix_ready) @(negedge clk);
  endtask

  task automatic feed(input logic m, input int nf, input int g0);
    int ac;
    ac = m ? AC625 : AC525;
    for (int fi = 0; fi < nf; fi++)
      for (int s = 0; s < 2 * ac; s++)
        for (int x = 0; x < W; x++) begin
          send(pat(g0 + fi, s, x));
          if ((x + s + fi) % 5 == 0) begin
            @(negedge clk);
            pix_valid = 1'b0;
          end
        end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // Scoreboard monitor
  logic       stalled = 1'b0;
  logic [7:0] stall_b;
  initial begin
    forever begin
      @(negedge clk);
      if (stalled && rst_n) chk(byte_valid && bo == stall_b, "R1", bo, stall_b);
      stalled = 1'b0;
      byte_ready = ($urandom % 4) != 0;
      #0.5;
      if (rst_n && q.size() > 0 && byte_valid) begin
        if (byte_ready) begin
          exp_t e;
          e = q.pop_front();
          chk(bo == e.b, e.tag, bo, e.b);
          chk(field == e.f, "R9", field, e.f);
        end else begin
          stalled = 1'b1;
          stall_b = bo;
        end
      end
    end
  end

  task automatic do_reset(input logic m);
    rst_n = 1'b0;
    mode = m;
    pix_valid = 1'b0;
    q.delete();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.2;
    // R10 reset state
    chk(byte_valid && bo == 8'hFF, "R10", bo, 8'hFF);
    chk(field == 1'b0, "R10", field, 0);
    chk(pix_ready == 1'b1, "R10", pix_ready, 1);
  endtask

  initial begin
    // 525-line run, two frames
    do_reset(1'b0);
    build(1'b0, 4, 0);
    feed(1'b0, 4, 0);
    while (q.size() != 0) @(negedge clk);
    // 625-line run; mode pin flipped mid-run must be ignored (R7)
    do_reset(1'b1);
    build(1'b1, 4, 10);
    fork
      feed(1'b1, 4, 10);
      begin
        repeat (300) @(negedge clk);
        mode = 1'b0;
      end
    join
    while (q.size() != 0) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule